// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a 16-bit converter that takes its data over a serial link. A host frames each transfer by driving an active-low select line. While the select is low, the host clocks one data bit in on every rising edge of the serial clock. The first bit sent is the most significant. The block collects the bits in a shift register. When a frame ends with exactly sixteen bits, the block keeps that word as the latest complete word. It then hands the word to a parallel code register, which stands in for the converter.

The hand-off runs in one of two update modes, chosen by a mode input. In the automatic mode, the code register takes the word as soon as the select line rises at the end of a good frame. In the strobe mode, the code register changes only on a falling edge of an active-low load input. If the load input is already low when a good frame ends, the copy happens at the end of that frame.

All serial pins pass through two-flop synchronisers into the system clock domain, and edges are detected there. The block raises a one-cycle update pulse for every write of the code register.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset, the code output is 0x0000, the update pulse is low, and the bit count is zero.
- R2: In each 16-bit frame, data is sampled on serial clock rising edges, and the first bit sampled becomes bit 15 of the code.
- R3: A frame may be sent as two 8-bit bursts with an idle gap between them, provided the select line stays low throughout. Such a frame loads the same code as a continuous one.
- R4: With the mode input low (automatic mode), a frame of exactly 16 rising edges loads the code on the select rising edge and produces exactly one update pulse.
- R5: A frame with any other count of rising edges (0, fewer than 16, or more than 16) is discarded. The code output keeps its value and no update pulse occurs.
- R6: With the mode input high (strobe mode), a completed frame does not change the code. A falling edge on the load input copies the latest complete word into the code register. A discarded frame does not replace that word.
- R7: In strobe mode, if the load input is held low while a frame is sent, the code takes the new word at the end of that frame.
- R8: The update pulse lasts one clock cycle, and the code output never changes without it.
- R9: Serial clock edges that arrive while the select line is high neither shift data nor count towards the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| sdi_i | input | 1 | Serial data, most significant bit first |
| load_n_i | input | 1 | Active-low load strobe (used in strobe mode) |
| strobe_mode_i | input | 1 | 0 = automatic update, 1 = update on load strobe |
| dac_code_o | output | WORD_W | Parallel converter code |
| dac_update_o | output | 1 | One-cycle pulse on every code register write |

## Verification
The hardest case to reach from the ports is the strobe mode with the load input already low before the frame starts. In that case the falling edge of the load input reloads the previous word, and the new word must still arrive at the end of the frame. The bench lowers the load input first and then sends a full frame. It checks both the final code and that exactly two update pulses occurred. Discarded frames are reached by sending frames with 0, 1, 8, 15, 17 and 24 clock edges. Ignored edges are reached by toggling the serial clock while the select line is high, just before a good frame.

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              load_n_i,
  input  logic              strobe_mode_i,
  output logic [WORD_W-1:0] dac_code_o,
  output logic              dac_update_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);
  localparam logic [3:0] PIN_IDLE = 4'b1100;

  logic [3:0]        sync_q [SYNC_STAGES];
  logic [3:0]        pins, pins_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shift_q, held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= PIN_IDLE;
      pins_d <= PIN_IDLE;
    end else begin
      sync_q[0] <= {load_n_i, cs_n_i, sclk_i, sdi_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      pins_d <= pins;
    end
  end

  assign pins = sync_q[SYNC_STAGES-1];

  wire cs_low     = !pins[2];
  wire cs_rise    = pins[2] && !pins_d[2];
  wire sclk_rise  = pins[1] && !pins_d[1];
  wire load_low   = !pins[3];
  wire load_fall  = !pins[3] && pins_d[3];
  wire shift_en   = cs_low && sclk_rise;
  wire frame_ok   = cs_rise && (bit_cnt == CNT_FULL);
  wire do_load    = strobe_mode_i ? ((frame_ok && load_low) || load_fall) : frame_ok;
  wire [WORD_W-1:0] next_code = frame_ok ? shift_q : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shift_q <= '0;
      held_q  <= '0;
    end else begin
      if (cs_rise) bit_cnt <= '0;
      else if (shift_en && bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + CNT_W'(1);
      if (shift_en) shift_q <= {shift_q[WORD_W-2:0], pins[0]};
      if (frame_ok) held_q <= shift_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code_o   <= '0;
      dac_update_o <= 1'b0;
    end else begin
      dac_update_o <= do_load;
      if (do_load) dac_code_o <= next_code;
    end
  end

  assert_auto_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !strobe_mode_i) |=> (dac_code_o == $past(shift_q)));

  assert_bad_frame_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != CNT_FULL && !(strobe_mode_i && load_fall)) |=> $stable(dac_code_o));

  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_mode_i && !load_fall && !(frame_ok && load_low)) |=> $stable(dac_code_o));

  assert_change_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code_o) |-> dac_update_o);
endmodule

// File: tb/serial_dac_frontend_tb.sv
module serial_dac_frontend_tb;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 0, sdi = 0, load_n = 1, strobe = 0;
  logic [15:0] dac;
  logic upd;
  int checks = 0, errors = 0, pulses = 0, run = 0, max_run = 0;
  bit done = 0;

  serial_dac_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .load_n_i(load_n), .strobe_mode_i(strobe), .dac_code_o(dac), .dac_update_o(upd)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && upd) begin
      pulses++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int gap_after);
    cs_n = 0;
    wait_clk(4);
    for (int b = 0; b < nbits; b++) begin
      sdi = (b < 16) ? w[15-b] : 1'b0;
      wait_clk(4);
      sclk = 1;
      wait_clk(4);
      sclk = 0;
      if (b + 1 == gap_after) wait_clk(20);
    end
    wait_clk(4);
    cs_n = 1;
    wait_clk(8);
  endtask

  task automatic strobe_load();
    load_n = 0;
    wait_clk(6);
    load_n = 1;
    wait_clk(8);
  endtask

  initial begin
    logic [15:0] w, prev;
    int p0;
    int bad_len [6] = '{0, 1, 8, 15, 17, 24};
    wait_clk(5);
    rst_n = 1;
    wait_clk(3);
    check("R1 code", dac, 0);
    check("R1 pulse", upd, 0);

    for (int i = 0; i < 50; i++) begin
      if (i < 16) w = 16'h1 << i;
      else if (i == 16) w = 16'hFFFF;
      else if (i == 17) w = 16'h0000;
      else w = 16'(i * 40503 + 7);
      p0 = pulses;
      send(w, 16, 0);
      check("R2 code", dac, w);
      check("R4 pulse count", pulses - p0, 1);
    end

    p0 = pulses;
    send(16'hA5C3, 16, 8);
    check("R3 burst code", dac, 16'hA5C3);
    check("R3 pulse count", pulses - p0, 1);

    prev = dac;
    foreach (bad_len[k]) begin
      p0 = pulses;
      send(16'h5A5A, bad_len[k], 0);
      check("R5 code kept", dac, prev);
      check("R5 no pulse", pulses - p0, 0);
    end

    sdi = 1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1; wait_clk(4);
      sclk = 0; wait_clk(4);
    end
    send(16'h0F0F, 16, 0);
    check("R9 code", dac, 16'h0F0F);

    strobe = 1;
    p0 = pulses;
    send(16'h1234, 16, 0);
    check("R6 held before strobe", dac, 16'h0F0F);
    check("R6 no pulse before strobe", pulses - p0, 0);
    strobe_load();
    check("R6 strobe code", dac, 16'h1234);
    check("R6 strobe pulse", pulses - p0, 1);
    send(16'h7777, 15, 0);
    strobe_load();
    check("R6 bad frame not latched", dac, 16'h1234);

    p0 = pulses;
    load_n = 0;
    wait_clk(8);
    send(16'hBEEF, 16, 0);
    check("R7 code at frame end", dac, 16'hBEEF);
    check("R7 pulse count", pulses - p0, 2);
    load_n = 1;
    wait_clk(8);

    check("R8 pulse width", max_run, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule